// File: doc/BRIEF.md
# Switch Port Status LED Driver

This block turns per-port PHY and MAC status into three active-low lamp outputs for each switch port: a link/activity lamp, a duplex/collision lamp and a speed lamp. The steady state of each lamp comes straight from the level inputs (link, duplex, speed). Short activity and collision pulses are stretched and shown as a blink on top of that steady state, so that a single frame or a single collision is still visible to a person looking at the panel.

One shared prescaler sets the blink rate for every port, so all blinking lamps flash in phase. Right after reset the block runs a lamp test that lights every output for a fixed number of clocks. A strap input is sampled once, on the first clock after reset is released, and selects single-colour or dual-colour operation. In dual-colour mode the speed lamp is only lit while the port has link.

Top module: `port_led_drv`

## Requirements
- R1: For the first POST_CYCLES clock edges after reset is released (and while reset is held), every lamp output is 0 (lit); from then on the outputs show port status.
- R2: Outside the lamp test, a port with link_up=0 drives its link/activity output to 1, and a port with link up and no pending activity drives it to 0.
- R3: A shared blink phase starts at "lit" when the lamp test ends and flips every BLINK_HALF clocks; while a port's activity stretch is pending and its link is up, its link/activity output equals the phase (0 in the lit half, 1 in the dark half).
- R4: An activity pulse makes the stretch pending for the next STRETCH_HALVES phase flips; a new pulse during the stretch restarts the count at STRETCH_HALVES.
- R5: Outside the lamp test and with no collision stretch pending, the duplex/collision output is 0 when full_duplex=1 and 1 when full_duplex=0.
- R6: A collision pulse stretches like R4, and while that stretch is pending the duplex/collision output equals the blink phase, whatever the duplex input.
- R7: Outside the lamp test, the speed output is 0 when speed_100=1 and 1 when speed_100=0, except as R9 states.
- R8: The colour-mode strap (0 = single colour, 1 = dual colour) is captured on the first clock edge after reset release; later changes of the strap have no effect until the next reset.
- R9: In dual-colour mode a port with link_up=0 drives its speed output to 1; in single-colour mode the speed output ignores link.
- R10: All ports use the same blink phase, so two ports blinking at the same time show the same output value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| colour_mode_strap | input | 1 | Mode strap, 1 = dual colour, sampled once after reset |
| link_up | input | NPORTS | Per-port link state, 1 = link up |
| speed_100 | input | NPORTS | Per-port speed, 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | NPORTS | Per-port duplex, 1 = full, 0 = half |
| activity_pulse | input | NPORTS | One-clock pulse per received or sent frame |
| collision_pulse | input | NPORTS | One-clock pulse per collision |
| led_link_n | output | NPORTS | Link/activity lamps, active low |
| led_dup_n | output | NPORTS | Duplex/collision lamps, active low |
| led_speed_n | output | NPORTS | Speed lamps, active low |

## Verification
The assertions assume the status inputs are synchronous to clk and that the strap is a level that only matters at the first edge after reset; they check the lamp test, the link-down and speed mappings and the one-time strap capture, none of which depend on pulse spacing. The stimulus changes the level inputs on falling edges, keeps link and duplex changes rare so the steady states are seen at length, fires activity and collision pulses both sparsely and back to back so stretch restarts occur, and toggles the strap after capture in both modes to show it is ignored.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic {
    LAMP_SINGLE = 1'b0,
    LAMP_DUAL   = 1'b1
  } lamp_mode_e;
endpackage

// File: rtl/led_post_seq.sv
module led_post_seq
  import led_pkg::*;
#(
  parameter int POST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_in,
  output logic       post_active,
  output logic       strap_done,
  output lamp_mode_e mode
);
  localparam int CNT_W = $clog2(POST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             done_q, done_d;
  lamp_mode_e       mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    done_d = done_q;
    mode_d = mode_q;
    if (!done_q) begin
      done_d = 1'b1;
      mode_d = lamp_mode_e'(strap_in);
    end
    if (act_q) begin
      if (cnt_q == LAST) act_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b1;
      done_q <= 1'b0;
      mode_q <= LAMP_SINGLE;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
      mode_q <= mode_d;
    end
  end

  assign post_active = act_q;
  assign strap_done  = done_q;
  assign mode        = mode_q;
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int BLINK_HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick,
  output logic phase
);
  localparam int PRE_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [PRE_W-1:0] WRAP = PRE_W'(BLINK_HALF - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             ph_q, ph_d;
  logic             tick;

  always_comb begin
    tick  = run && (pre_q == WRAP);
    pre_d = pre_q;
    ph_d  = ph_q;
    if (run) begin
      if (tick) begin
        pre_d = '0;
        ph_d  = ~ph_q;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end

  assign half_tick = tick;
  assign phase     = ph_q;
endmodule

// File: rtl/led_port_lane.sv
module led_port_lane
  import led_pkg::*;
#(
  parameter int STRETCH_HALVES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       post_active,
  input  lamp_mode_e mode,
  input  logic       half_tick,
  input  logic       phase,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       activity_pulse,
  input  logic       collision_pulse,
  output logic       led_link_n,
  output logic       led_dup_n,
  output logic       led_speed_n
);
  localparam int HOLD_W = $clog2(STRETCH_HALVES + 1);
  localparam logic [HOLD_W-1:0] LOAD = HOLD_W'(STRETCH_HALVES);

  logic [HOLD_W-1:0] act_q, act_d;
  logic [HOLD_W-1:0] col_q, col_d;

  function automatic logic [HOLD_W-1:0] next_hold(
    input logic [HOLD_W-1:0] cur, input logic pulse, input logic tick);
    if (pulse)                  return LOAD;
    else if (tick && cur != '0) return cur - 1'b1;
    else                        return cur;
  endfunction

  always_comb begin
    act_d = next_hold(act_q, activity_pulse, half_tick);
    col_d = next_hold(col_q, collision_pulse, half_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      col_q <= '0;
    end else begin
      act_q <= act_d;
      col_q <= col_d;
    end
  end

  always_comb begin
    if (post_active) begin
      led_link_n  = 1'b0;
      led_dup_n   = 1'b0;
      led_speed_n = 1'b0;
    end else begin
      if (!link_up)          led_link_n = 1'b1;
      else if (act_q != '0)  led_link_n = phase;
      else                   led_link_n = 1'b0;

      if (col_q != '0)       led_dup_n = phase;
      else                   led_dup_n = ~full_duplex;

      if (mode == LAMP_DUAL && !link_up) led_speed_n = 1'b1;
      else                               led_speed_n = ~speed_100;
    end
  end
endmodule

// File: rtl/port_led_drv.sv
module port_led_drv
  import led_pkg::*;
#(
  parameter int NPORTS         = 6,
  parameter int BLINK_HALF     = 1500000,
  parameter int POST_CYCLES    = 25000000,
  parameter int STRETCH_HALVES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              colour_mode_strap,
  input  logic [NPORTS-1:0] link_up,
  input  logic [NPORTS-1:0] speed_100,
  input  logic [NPORTS-1:0] full_duplex,
  input  logic [NPORTS-1:0] activity_pulse,
  input  logic [NPORTS-1:0] collision_pulse,
  output logic [NPORTS-1:0] led_link_n,
  output logic [NPORTS-1:0] led_dup_n,
  output logic [NPORTS-1:0] led_speed_n
);
  logic       post_active;
  logic       strap_done;
  lamp_mode_e mode;
  logic       half_tick;
  logic       phase;

  led_post_seq #(.POST_CYCLES(POST_CYCLES)) u_post (
    .clk(clk), .rst_n(rst_n), .strap_in(colour_mode_strap),
    .post_active(post_active), .strap_done(strap_done), .mode(mode)
  );

  led_blink_timer #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .run(~post_active),
    .half_tick(half_tick), .phase(phase)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    led_port_lane #(.STRETCH_HALVES(STRETCH_HALVES)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .post_active(post_active), .mode(mode),
      .half_tick(half_tick), .phase(phase),
      .link_up(link_up[p]), .speed_100(speed_100[p]),
      .full_duplex(full_duplex[p]),
      .activity_pulse(activity_pulse[p]),
      .collision_pulse(collision_pulse[p]),
      .led_link_n(led_link_n[p]), .led_dup_n(led_dup_n[p]),
      .led_speed_n(led_speed_n[p])
    );
  end
endmodule

// File: rtl/port_led_drv_chk.sv
module port_led_drv_chk
  import led_pkg::*;
#(
  parameter int NPORTS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              colour_mode_strap,
  input logic              post_active,
  input logic              strap_done,
  input lamp_mode_e        mode,
  input logic [NPORTS-1:0] link_up,
  input logic [NPORTS-1:0] speed_100,
  input logic [NPORTS-1:0] led_link_n,
  input logic [NPORTS-1:0] led_dup_n,
  input logic [NPORTS-1:0] led_speed_n
);
  a_r1_lamp_test_all_lit: assert property (@(posedge clk) disable iff (!rst_n)
    post_active |-> (led_link_n == '0 && led_dup_n == '0 && led_speed_n == '0));

  a_r1_lamp_test_once: assert property (@(posedge clk) disable iff (!rst_n)
    !post_active |=> !post_active);

  a_r2_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !post_active |-> ((~link_up & ~led_link_n) == '0));

  a_r7_speed_with_link: assert property (@(posedge clk) disable iff (!rst_n)
    !post_active |-> (((led_speed_n ^ ~speed_100) & link_up) == '0));

  a_r8_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> ($stable(mode) && strap_done));

  a_r8_strap_captured: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |=> (mode == lamp_mode_e'($past(colour_mode_strap))));

  a_r9_dual_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_active && mode == LAMP_DUAL) |-> ((~link_up & ~led_speed_n) == '0));
endmodule

bind port_led_drv port_led_drv_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .colour_mode_strap(colour_mode_strap),
  .post_active(post_active), .strap_done(strap_done), .mode(mode),
  .link_up(link_up), .speed_100(speed_100),
  .led_link_n(led_link_n), .led_dup_n(led_dup_n), .led_speed_n(led_speed_n)
);

// File: tb/port_led_drv_test.sv
module port_led_drv_test;
  localparam int N    = 4;
  localparam int HALF = 8;
  localparam int POST = 20;
  localparam int STR  = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strap = 1'b0;
  logic [N-1:0] link = '0, spd = '0, fdx = '0, act = '0, col = '0;
  logic [N-1:0] led_l, led_d, led_s;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  port_led_drv #(.NPORTS(N), .BLINK_HALF(HALF), .POST_CYCLES(POST),
                 .STRETCH_HALVES(STR)) uut (
    .clk(clk), .rst_n(rst_n), .colour_mode_strap(strap),
    .link_up(link), .speed_100(spd), .full_duplex(fdx),
    .activity_pulse(act), .collision_pulse(col),
    .led_link_n(led_l), .led_dup_n(led_d), .led_speed_n(led_s)
  );

  always #10 clk = ~clk;

  // reference state built from the requirements
  bit m_first, m_post, m_dual, m_phase;
  int m_pc, m_pre;
  int m_ah [N];
  int m_ch [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_first <= 1; m_post <= 1; m_dual <= 0; m_phase <= 0;
      m_pc <= 0; m_pre <= 0;
      for (int i = 0; i < N; i++) begin m_ah[i] <= 0; m_ch[i] <= 0; end
    end else begin
      bit tick;
      tick = !m_post && (m_pre == HALF - 1);
      if (m_first) begin m_first <= 0; m_dual <= strap; end
      if (m_post) begin
        if (m_pc == POST - 1) m_post <= 0; else m_pc <= m_pc + 1;
      end else if (tick) begin
        m_pre <= 0; m_phase <= ~m_phase;
      end else m_pre <= m_pre + 1;
      for (int i = 0; i < N; i++) begin
        if (act[i]) m_ah[i] <= STR; else if (tick && m_ah[i] > 0) m_ah[i] <= m_ah[i] - 1;
        if (col[i]) m_ch[i] <= STR; else if (tick && m_ch[i] > 0) m_ch[i] <= m_ch[i] - 1;
      end
    end
  end

  function automatic bit exp_link(int i);
    if (m_post || !rst_n) return 0;
    if (!link[i]) return 1;
    return (m_ah[i] > 0) ? m_phase : 1'b0;
  endfunction
  function automatic bit exp_dup(int i);
    if (m_post || !rst_n) return 0;
    return (m_ch[i] > 0) ? m_phase : ~fdx[i];
  endfunction
  function automatic bit exp_spd(int i);
    if (m_post || !rst_n) return 0;
    if (m_dual && !link[i]) return 1;
    return ~spd[i];
  endfunction

  task automatic chk(string req, int port, bit act_v, bit exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s port %0d cycle %0d: actual %b expected %b", req, port, cyc, act_v, exp_v);
    end
  endtask

  // compares every lamp against the reference, at the falling edge
  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      chk(m_post ? "R1" : ((link[i] && m_ah[i] > 0) ? "R3/R4" : "R2"), i, led_l[i], exp_link(i));
      chk(m_post ? "R1" : ((m_ch[i] > 0) ? "R6" : "R5"), i, led_d[i], exp_dup(i));
      chk(m_post ? "R1" : (m_dual ? "R9" : "R7/R8"), i, led_s[i], exp_spd(i));
    end
  endtask

  task automatic step_rand(int act_rate, int col_rate, bit flip_strap);
    @(negedge clk);
    cyc++;
    check_all();
    act = '0; col = '0;
    for (int i = 0; i < N; i++) begin
      if ($urandom % 40 == 0) link[i] = ~link[i];
      if ($urandom % 50 == 0) spd[i]  = ~spd[i];
      if ($urandom % 50 == 0) fdx[i]  = ~fdx[i];
      if ($urandom % act_rate == 0) act[i] = 1'b1;
      if ($urandom % col_rate == 0) col[i] = 1'b1;
    end
    if (flip_strap && $urandom % 30 == 0) strap = ~strap;
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 0; act = '0; col = '0;
    strap = mode;
    repeat (2) @(negedge clk);
    check_all(); // R1: reset state
    rst_n = 1;
  endtask

  // R10: two ports blinking together must match
  task automatic check_in_phase();
    @(negedge clk);
    cyc++;
    check_all();
    link = '1; act = 2'b11;
    repeat (3 * HALF) begin
      @(negedge clk);
      cyc++;
      act = '0;
      check_all();
      chk("R10", 1, led_l[1], led_l[0]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // single-colour run, strap toggled after capture (R8)
    do_reset(1'b0);
    for (int k = 0; k < POST + 5; k++) step_rand(1000, 1000, 1'b0);
    check_in_phase();
    for (int k = 0; k < 3000; k++) step_rand(20, 25, 1'b1);
    for (int k = 0; k < 1000; k++) step_rand(3, 4, 1'b1); // back-to-back pulses, R4 restarts
    // dual-colour run
    do_reset(1'b1);
    link = 4'b0101;
    for (int k = 0; k < POST + 5; k++) step_rand(1000, 1000, 1'b0);
    for (int k = 0; k < 3000; k++) step_rand(20, 25, 1'b1);
    check_in_phase();
    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule